// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a single external interrupt request pin and converts qualifying activity on it into a latched status flag. The flag can also drive an interrupt request to the processor. Software reaches the block through one 8-bit control/status register on a simple register bus. That register holds the following bits:

- pin enable
- edge polarity
- detection mode
- interrupt enable
- the read-only flag
- a write-only acknowledge

The pin is asynchronous, so it first passes through a two-flop synchroniser. A detector then compares the synchronised value with its value one clock earlier to find edges. In edge-and-level mode it also treats a sustained active level as an event. While the pin function is enabled, the block selects a pull-up or a pull-down resistor on the pin. The choice depends on the polarity, so that the idle level is the inactive one.

In edge-and-level mode the active level keeps producing events. An acknowledge therefore cannot clear the flag until the pin leaves its active level. This lets level-driven sources be serviced without losing requests.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every readable register bit is 0, the interrupt request is 0, and both pull selects are 0.
- R2: While the enable bit (bit 4) is 0, no pin activity sets the flag.
- R3: With enable at 1, polarity (bit 5) at 0 selects only the pull-up, and polarity at 1 selects only the pull-down. With enable at 0, neither pull is selected.
- R4: The flag reads at bit 3. After a qualifying pin change is first sampled on a rising edge, the flag becomes 1 on the third rising edge counted from that one, and is still 0 after the second.
- R5: Writing a register value with bit 2 at 1 clears the flag on that write's clock edge. A write with bit 2 at 0 leaves the flag unchanged. Bit 2 always reads 0.
- R6: The interrupt request output equals the flag ANDed with the interrupt-enable bit (bit 1).
- R7: With mode (bit 0) at 0 and polarity at 0, a falling edge sets the flag and a rising edge does not.
- R8: With mode at 0 and polarity at 1, a rising edge sets the flag and a falling edge does not.
- R9: With mode at 1, a sustained active level (low for polarity 0, high for polarity 1) sets the flag. An acknowledge issued while that level persists leaves the flag at 1. Once the pin has become inactive, an acknowledge clears the flag.
- R10: When an acknowledge write and a qualifying event occur in the same cycle, the flag stays at 1.
- R11: Bits 5, 4, 1 and 0 read back as last written. Bits 7 and 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| pullup_sel | output | 1 | Selects the pin pull-up resistor |
| pulldown_sel | output | 1 | Selects the pin pull-down resistor |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Each result has its own due point:

- **Flag:** a pin change sampled on one rising edge shows up in the flag after the third rising edge from that one.
- **Interrupt request:** it follows the flag in the same cycle.
- **Acknowledge:** it takes effect on the edge that performs the write.
- **Pull selects and read-back:** these are combinational from the register.

The vector walk waits four cycles after each pin change, which leaves a one-cycle margin, before it samples at a falling edge. A directed test samples the flag exactly after the second and the third edge to pin down the latency. The same test places the acknowledge in the very cycle the event is present.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W   = 8;
  localparam int B_MODE  = 0;
  localparam int B_IE    = 1;
  localparam int B_ACK   = 2;
  localparam int B_FLAG  = 3;
  localparam int B_EN    = 4;
  localparam int B_POL   = 5;

  typedef struct packed {
    logic pol;   // 1: rising/high active, 0: falling/low active
    logic en;
    logic ie;
    logic mode;  // 1: edge and level, 0: edge only
  } ctl_t;

  // Event rule: edge toward the active level, or (level mode) active level held.
  function automatic logic qualify(input logic mode, input logic pol,
                                   input logic cur, input logic prev);
    logic at_active;
    logic edge_hit;
    at_active = (cur == pol);
    edge_hit  = at_active && (prev != cur);
    return edge_hit || (mode && at_active);
  endfunction
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  localparam int TOT = STAGES + 1;
  logic [TOT-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[TOT-2:0], d_i};
  end

  assign q_o      = chain[STAGES-1];
  assign q_prev_o = chain[STAGES];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect (
  input  logic enable_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic cur_i,
  input  logic prev_i,
  output logic evt_o
);
  import extirq_pkg::*;
  assign evt_o = enable_i && qualify(mode_i, pol_i, cur_i, prev_i);
endmodule

// File: rtl/extirq_flag.sv
module extirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (evt_i) flag_o <= 1'b1;
    else if (ack_i) flag_o <= 1'b0;
  end

  // R5: a lone acknowledge clears the flag
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i) |=> !flag_o);
  // R10: an event wins over a same-cycle acknowledge
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_o);
  // R4: the flag only rises after an event
  a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(evt_i));
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       pullup_sel,
  output logic       pulldown_sel,
  output logic       irq_o
);
  import extirq_pkg::*;

  ctl_t ctl_q;
  logic pin_s, pin_p, evt, ack, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (bus_we) begin
      ctl_q.pol  <= bus_wdata[B_POL];
      ctl_q.en   <= bus_wdata[B_EN];
      ctl_q.ie   <= bus_wdata[B_IE];
      ctl_q.mode <= bus_wdata[B_MODE];
    end
  end

  assign ack = bus_we && bus_wdata[B_ACK];

  extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s), .q_prev_o(pin_p));

  extirq_detect u_det (
    .enable_i(ctl_q.en), .mode_i(ctl_q.mode), .pol_i(ctl_q.pol),
    .cur_i(pin_s), .prev_i(pin_p), .evt_o(evt));

  extirq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_i(ack), .flag_o(flag));

  always_comb begin
    bus_rdata         = '0;
    bus_rdata[B_POL]  = ctl_q.pol;
    bus_rdata[B_EN]   = ctl_q.en;
    bus_rdata[B_FLAG] = flag;
    bus_rdata[B_IE]   = ctl_q.ie;
    bus_rdata[B_MODE] = ctl_q.mode;
  end

  assign pullup_sel   = ctl_q.en && !ctl_q.pol;
  assign pulldown_sel = ctl_q.en &&  ctl_q.pol;
  assign irq_o        = flag && ctl_q.ie;

  // R2: disabled pin cannot set a clear flag
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !flag) |=> !flag);
  // R3: never both pulls at once
  a_r3_one_pull: assert property (@(posedge clk) disable iff (!rst_n)
    !(pullup_sel && pulldown_sel));
  // R9: held active level in level mode keeps the flag set
  a_r9_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && ctl_q.mode && (pin_s == ctl_q.pol)) |=> flag);
  // R5: acknowledge field never reads back
  a_r5_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[B_ACK]);
endmodule

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // row: {ctrl[7:0], pin_start, pin_end, exp_flag}
  localparam logic [10:0] VEC [NV] = '{
    {8'h00, 1'b1, 1'b0, 1'b0},  // R2 disabled, falling
    {8'h10, 1'b1, 1'b0, 1'b1},  // R7 falling sets
    {8'h10, 1'b0, 1'b1, 1'b0},  // R7 rising ignored
    {8'h30, 1'b0, 1'b1, 1'b1},  // R8 rising sets
    {8'h30, 1'b1, 1'b0, 1'b0},  // R8 falling ignored
    {8'h12, 1'b1, 1'b0, 1'b1},  // R6 irq enabled
    {8'h31, 1'b0, 1'b1, 1'b1},  // R9 high level
    {8'h11, 1'b1, 1'b1, 1'b0},  // R9 inactive level
    {8'h20, 1'b0, 1'b1, 1'b0}   // R2 disabled, rising
  };

  logic clk = 0, rst_n = 0, pin = 0, we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic pu, pd, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extirq_ctrl u_extirq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pullup_sel(pu), .pulldown_sel(pd), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic flagv(); return rdata[3]; endfunction

  initial begin
    wait_cyc(3);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(irq == 0 && pu == 0 && pd == 0, "R1 outputs", {irq, pu, pd}, 0);
    rst_n = 1;
    wait_cyc(2);
    chk(rdata == 8'h00, "R1 after release", rdata, 0);

    // vector walk
    for (int k = 0; k < NV; k++) begin
      logic [7:0] c;
      logic exp_f;
      c = VEC[k][10:3];
      exp_f = VEC[k][0];
      wr(c);
      pin = VEC[k][2];
      wait_cyc(4);
      wr(c | 8'h04);
      wait_cyc(1);
      chk(flagv() == 0, "R5 setup ack", flagv(), 0);
      pin = VEC[k][1];
      wait_cyc(4);
      chk(flagv() == exp_f, "R2/R7/R8/R9 vector flag", flagv(), exp_f);
      chk(irq == (exp_f & c[1]), "R6 irq", irq, exp_f & c[1]);
    end

    // R3 pull selects
    wr(8'h10); chk(pu == 1 && pd == 0, "R3 pol0", {pu, pd}, 2'b10);
    wr(8'h30); chk(pu == 0 && pd == 1, "R3 pol1", {pu, pd}, 2'b01);
    wr(8'h00); chk(pu == 0 && pd == 0, "R3 disabled", {pu, pd}, 0);

    // R11 read-back map (pin low, level-high mode: inactive)
    pin = 0; wait_cyc(4);
    wr(8'hFF); wait_cyc(1);
    chk((rdata & 8'hF7) == 8'h33, "R11 readback", rdata & 8'hF7, 8'h33);
    chk(rdata[2] == 0, "R5 ack reads 0", rdata[2], 0);
    chk(flagv() == 0, "R11 flag after ack", flagv(), 0);

    // R5 write 0 to ack keeps flag
    wr(8'h10); pin = 1; wait_cyc(4);
    wr(8'h04 | 8'h10); pin = 0; wait_cyc(4);
    chk(flagv() == 1, "R5 flag set", flagv(), 1);
    wr(8'h10); wait_cyc(1);
    chk(flagv() == 1, "R5 ack0 no effect", flagv(), 1);
    wr(8'h14);
    chk(flagv() == 0, "R5 ack1 clears", flagv(), 0);

    // R9 level low: ack while active keeps flag, then clears once inactive
    wr(8'h11); wait_cyc(4);
    chk(flagv() == 1, "R9 level sets", flagv(), 1);
    wr(8'h15); wait_cyc(1);
    chk(flagv() == 1, "R9 ack while active", flagv(), 1);
    pin = 1; wait_cyc(4);
    wr(8'h15); wait_cyc(1);
    chk(flagv() == 0, "R9 ack after release", flagv(), 0);

    // R4 latency and R10 ack-vs-event in edge mode, falling active
    wr(8'h10); wait_cyc(2);
    wr(8'h14); wait_cyc(1);
    @(negedge clk); pin = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(flagv() == 0, "R4 not yet after 2 edges", flagv(), 0);
    we = 1; wdata = 8'h14;
    @(posedge clk);
    @(negedge clk); we = 0;
    chk(flagv() == 1, "R4/R10 set on 3rd edge despite ack", flagv(), 1);
    wr(8'h14);
    chk(flagv() == 0, "R5 later ack clears", flagv(), 0);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule